// File: doc/BRIEF.md
# Edge-Time Capture Timer

This block runs a 24-bit free-running counter and copies its value into a capture register each time a chosen transition appears on an asynchronous input pin. The counter is formed from a 16-bit main count widened by an 8-bit prescaler extension. It counts up or down and wraps at a programmable interval. A capture never pauses or disturbs the count, so software can timestamp a series of pin events against one continuous timebase.

Each capture sets a sticky event flag. The flag is cleared only by a write-one-to-clear pulse. A mask bit routes the flag onto an interrupt line. All configuration inputs are synchronous levels sampled on every clock. A new interval value is therefore used from the next count step onward. The pin passes through a two-stage synchronizer before the edge detector.

Top module: `edge_capture_timer`

## Requirements
- R1: While reset is asserted, and at its release, the capture value, the event flag and the interrupt are all 0. The counter also starts at 0.
- R2: With the enable high and the direction bit at 1 (up), the counter advances by one each clock until it reaches the interval value. On the following clock it returns to 0. If the counter already exceeds a newly lowered interval, it also returns to 0.
- R3: With the enable high and the direction bit at 0 (down), the counter decreases by one each clock until it reaches 0. On the following clock it loads the interval value.
- R4: The edge select uses these codes: 2'b00 captures rising edges only, 2'b01 captures falling edges only, and 2'b10 or 2'b11 captures both. Transitions of a kind that is not selected cause no capture and no flag.
- R5: On a selected edge, the capture register takes the counter value, and the counter continues its normal step in the same clock. Between captures, the capture register holds its value.
- R6: Every capture sets the event flag. The flag stays set until a clock in which the clear input is 1 and no capture occurs. If a capture and a clear fall in the same clock, the flag remains set.
- R7: The interrupt output equals the event flag ANDed with the mask input.
- R8: A change to the interval input is applied by the very next wrap or reload decision, with no restart of the counter.
- R9: A pin transition that is stable before clock edge k updates the capture register at edge k+2. The value stored is the counter value held just before that edge.
- R10: While the enable is low, the counter holds its value, and neither the capture register nor the event flag changes, except that a clear still lowers the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Run enable for counting and capture |
| cfg_count_up | input | 1 | Direction: 1 up, 0 down |
| cfg_edge_sel | input | 2 | Capture edge code (see R4) |
| cfg_interval | input | 24 | Wrap or reload interval |
| cfg_irq_mask | input | 1 | Interrupt mask, 1 passes the flag |
| pin_in | input | 1 | Asynchronous event pin |
| evt_clear | input | 1 | Write-one-to-clear for the event flag |
| cap_value | output | 24 | Counter value at the latest capture |
| evt_flag | output | 1 | Sticky raw capture flag |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest case to reach from the ports is a capture and a clear landing in the same clock. The capture moment sits two synchronizer stages behind the pin, so it cannot be aimed directly. The stimulus therefore holds the clear high for whole stretches while toggling the pin at random, which makes that coincidence occur many times. Interval changes are made while the counter sits above the new value, and down-count runs use an all-ones interval, so wrap-by-comparison and full-width reload values both appear in the captured data.

// File: rtl/ect_pkg.sv
package ect_pkg;

   typedef enum logic [1:0] {
      EDGE_RISE  = 2'b00,
      EDGE_FALL  = 2'b01,
      EDGE_BOTH  = 2'b10,
      EDGE_BOTH2 = 2'b11
   } edge_sel_e;

   function automatic logic edge_hit(edge_sel_e sel, logic rise, logic fall);
      case (sel)
         EDGE_RISE: return rise;
         EDGE_FALL: return fall;
         default:   return rise | fall;
      endcase
   endfunction

endpackage

// File: rtl/ect_sync.sv
module ect_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   output logic rise_o,
   output logic fall_o
);
   localparam int LAST = STAGES - 1;

   logic [STAGES-1:0] sh_q;
   logic              prev_q;

   initial begin
      if (STAGES < 2) $fatal(1, "ect_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], pin_in};
         prev_q <= sh_q[LAST];
      end
   end

   assign rise_o = sh_q[LAST] & ~prev_q;
   assign fall_o = ~sh_q[LAST] & prev_q;

   p_edge_from_history_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/ect_counter.sv
module ect_counter #(
   parameter int MAIN_W = 16,
   parameter int PRE_W  = 8,
   localparam int CNT_W = MAIN_W + PRE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             up,
   input  logic [CNT_W-1:0] interval,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   initial begin
      if (MAIN_W < 1 || PRE_W < 0) $fatal(1, "ect_counter: bad width");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (en) begin
         if (up) cnt_q <= (cnt_q >= interval) ? '0 : cnt_q + ONE;
         else    cnt_q <= (cnt_q == '0) ? interval : cnt_q - ONE;
      end
   end

   assign cnt_o = cnt_q;

   p_up_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en && up && (cnt_q < interval) |=> cnt_q == $past(cnt_q) + ONE);
   p_up_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en && up && (cnt_q >= interval) |=> cnt_q == '0);
   p_down_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      en && !up && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE);
   p_down_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
      en && !up && (cnt_q == '0) |=> cnt_q == $past(interval));
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(cnt_q));
endmodule

// File: rtl/ect_capture.sv
module ect_capture #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic [CNT_W-1:0] cnt,
   input  logic             clr,
   input  logic             mask,
   output logic [CNT_W-1:0] cap_o,
   output logic             raw_o,
   output logic             irq_o
);
   logic [CNT_W-1:0] cap_q;
   logic             raw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q <= '0;
         raw_q <= 1'b0;
      end else begin
         if (hit) cap_q <= cnt;
         if (hit)      raw_q <= 1'b1;
         else if (clr) raw_q <= 1'b0;
      end
   end

   assign cap_o = cap_q;
   assign raw_o = raw_q;
   assign irq_o = raw_q & mask;

   p_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (cap_q == $past(cnt)) && raw_q);
   p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(cap_q));
   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !hit |=> !raw_q);
   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      raw_q && !clr |=> raw_q);
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer #(
   parameter int MAIN_W      = 16,
   parameter int PRE_W       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W      = MAIN_W + PRE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_en,
   input  logic             cfg_count_up,
   input  logic [1:0]       cfg_edge_sel,
   input  logic [CNT_W-1:0] cfg_interval,
   input  logic             cfg_irq_mask,
   input  logic             pin_in,
   input  logic             evt_clear,
   output logic [CNT_W-1:0] cap_value,
   output logic             evt_flag,
   output logic             irq
);
   import ect_pkg::*;

   logic             rise, fall, hit;
   logic [CNT_W-1:0] cnt;

   ect_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .rise_o(rise), .fall_o(fall));

   ect_counter #(.MAIN_W(MAIN_W), .PRE_W(PRE_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(cfg_en), .up(cfg_count_up),
      .interval(cfg_interval), .cnt_o(cnt));

   assign hit = cfg_en & edge_hit(edge_sel_e'(cfg_edge_sel), rise, fall);

   ect_capture #(.CNT_W(CNT_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .hit(hit), .cnt(cnt), .clr(evt_clear),
      .mask(cfg_irq_mask), .cap_o(cap_value), .raw_o(evt_flag), .irq_o(irq));

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> $stable(cap_value) && !(evt_flag && !$past(evt_flag)));
   p_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_edge_sel == 2'b00) && fall |=> $stable(cap_value));
endmodule

// File: tb/edge_capture_timer_tb_top.sv
module edge_capture_timer_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0, up = 1'b0, mask = 1'b0, pin = 1'b0, clr = 1'b0;
   logic [1:0]  sel = 2'b00;
   logic [23:0] iv = 24'd0;
   logic [23:0] cap_value;
   logic        evt_flag, irq;

   int    checks = 0, errors = 0;
   string tag = "R1";
   bit    done = 1'b0;

   logic [23:0] m_cnt, m_cap;
   logic        m_flag, m_s1, m_s2, m_s3, m_hit;

   always #(CLK_PERIOD/2) clk = ~clk;

   edge_capture_timer dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_en(en), .cfg_count_up(up),
      .cfg_edge_sel(sel), .cfg_interval(iv), .cfg_irq_mask(mask),
      .pin_in(pin), .evt_clear(clr), .cap_value(cap_value),
      .evt_flag(evt_flag), .irq(irq));

   // reference model built from the requirements
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = '0; m_cap = '0; m_flag = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      end else begin
         m_hit = en && ((sel == 2'b00 && m_s2 && !m_s3) ||
                        (sel == 2'b01 && !m_s2 && m_s3) ||
                        (sel[1] && (m_s2 != m_s3)));
         if (m_hit) m_cap = m_cnt;
         if (m_hit) m_flag = 1;
         else if (clr) m_flag = 0;
         if (en) begin
            if (up) m_cnt = (m_cnt >= iv) ? 24'd0 : m_cnt + 24'd1;
            else    m_cnt = (m_cnt == 24'd0) ? iv : m_cnt - 24'd1;
         end
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin;
      end
   end

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         chk(tag, "capture", 32'(cap_value), 32'(m_cap));
         chk(tag, "flag", 32'(evt_flag), 32'(m_flag));
         chk("R7", "irq", 32'(irq), 32'(m_flag & mask));
      end
   end

   task automatic run(int n, int p_pin, int p_clr);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (($urandom % 100) < p_pin) pin = ~pin;
         clr = (($urandom % 100) < p_clr);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_up();
   end

   initial begin
      void'($urandom(32'd20240917));
      repeat (3) @(negedge clk);
      chk("R1", "capture in reset", 32'(cap_value), 32'd0);
      chk("R1", "flag in reset", 32'(evt_flag), 32'd0);
      chk("R1", "irq in reset", 32'(irq), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "capture after reset", 32'(cap_value), 32'd0);

      // R9 directed: single rising pulse, latency and captured value
      tag = "R9"; en = 1; up = 1; iv = 24'd1000; mask = 1; sel = 2'b00;
      repeat (5) @(negedge clk);
      pin = 1; repeat (6) @(negedge clk);
      pin = 0; repeat (6) @(negedge clk);

      tag = "R2"; iv = 24'd40;
      run(400, 20, 10);
      tag = "R3"; up = 0; sel = 2'b01; iv = 24'd33;
      run(400, 20, 10);
      tag = "R4"; sel = 2'b00; run(200, 25, 5);
      sel = 2'b01; run(200, 25, 5);
      sel = 2'b11; run(200, 25, 5);
      sel = 2'b10; run(200, 25, 5);

      // R8: shrink interval while counter sits above it, in both directions
      tag = "R8"; up = 1; iv = 24'd500; run(120, 20, 10);
      iv = 24'd7; run(120, 20, 10);
      up = 0; iv = 24'd300; run(60, 20, 10);
      iv = 24'd5; run(120, 20, 10);

      // R3 full-width reload value
      tag = "R3"; iv = 24'hFFFFFF; run(300, 20, 10);

      // R6: clear held high while captures keep landing
      tag = "R6"; sel = 2'b10; up = 1; iv = 24'd63;
      clr = 1;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (($urandom % 100) < 30) pin = ~pin;
         clr = 1;
      end
      clr = 0; run(40, 0, 0);

      // R7: mask off and on
      tag = "R7"; mask = 0; run(200, 20, 10);
      mask = 1; run(100, 20, 10);

      // R10: enable toggled randomly
      tag = "R10";
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         if (($urandom % 100) < 25) pin = ~pin;
         clr = (($urandom % 100) < 8);
         if (($urandom % 100) < 6) en = ~en;
         if (($urandom % 100) < 2) up = ~up;
      end

      // R5: random mix of everything
      tag = "R5"; en = 1;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (($urandom % 100) < 20) pin = ~pin;
         clr = (($urandom % 100) < 10);
         if (($urandom % 100) < 2) sel = 2'($urandom);
         if (($urandom % 100) < 2) iv = 24'($urandom % 200);
         if (($urandom % 100) < 1) up = ~up;
         if (($urandom % 100) < 3) mask = ~mask;
      end
      @(negedge clk);
      finish_up();
   end
endmodule